// File: doc/BRIEF.md
# Hardware Task Timeslot Scheduler

This block decides, on every clock, which of up to four hardware tasks may issue an instruction. Software loads a 32-bit schedule word that is split into sixteen 2-bit slots, each naming the task that owns one clock. The scheduler walks the slots in ascending order and starts again at the first slot after the last one. A sixteen-slot table gives an even split among one, two or four tasks.

Three tasks cannot share sixteen slots evenly. The spare slot would make the order of same-task instructions in the pipeline unpredictable. For this reason the schedule word with every bit set is reserved. Loading it switches the block to a fixed rotation of tasks 0, 1, 2, so each of the three tasks issues exactly once in every three clocks.

A stall input freezes the scheduler. The result appears on a registered task number with a valid flag.

Top module: `tsched_top`

## Requirements
- R1: During and after synchronous reset `issue_valid` is 0 and `issue_task` is 0. The schedule word resets to zero, so with no write every issue cycle after reset names task 0.
- R2: In table mode the k-th issue after a schedule write names slot k. Slot n sits in bits [2n+1:2n] of the word, so slot 0 is bits [1:0] and slot 15 is bits [31:30].
- R3: In table mode the slot after slot 15 is slot 0, so the issue sequence repeats with a period of 16.
- R4: Writing 32'hFFFF_FFFF selects rotation mode. Issues then run 0,1,2,0,1,2,… starting with task 0 and never name task 3.
- R5: Any other written value, including values that differ from all ones in only one bit, keeps table mode and follows R2.
- R6: The clock edge that takes a write produces no issue (`issue_valid` is 0). The next edge issues slot 0, or task 0 in rotation mode.
- R7: On an edge where `stall` is high and no write is taken, `issue_valid` goes to 0 and `issue_task` holds. The slot position or rotation position also holds, so issuing resumes with the next unissued entry.
- R8: A write is taken even when `stall` is high. After the stall ends, the first issue is slot 0, or task 0 in rotation mode.
- R9: Writing an ordinary value while in rotation mode returns the block to table mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sched_we | input | 1 | Write strobe for the schedule word |
| sched_wdata | input | 32 | Schedule word: 16 slots of 2-bit task numbers |
| stall | input | 1 | Freezes the scheduler for the cycle |
| issue_task | output | 2 | Task granted the issue slot |
| issue_valid | output | 1 | High when `issue_task` is a real issue |

## Verification
The bench checks the ends of the slot word (bit pair [1:0] against [31:30]) and the wrap from slot 15 back to slot 0. A design with a reversed slot order or a short wrap would issue the wrong task at exactly those points. Values one bit away from all ones are loaded to catch a decoder that compares too few bits and drops into rotation mode by mistake. Stalls are placed in the middle of both modes, and a write is made during a stall. These catch a pointer that keeps moving while frozen, a task output that clears instead of holding, and a restart that is lost when the write is masked by the stall.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

  typedef enum logic {
    MODE_TABLE = 1'b0,
    MODE_TRIO  = 1'b1
  } sched_mode_e;

endpackage

// File: rtl/tsched_table.sv
module tsched_table
  import tsched_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int TASK_W    = 2,
  localparam int REG_W    = NUM_SLOTS * TASK_W,
  localparam int PTR_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [PTR_W-1:0]  slot_idx,
  output logic [TASK_W-1:0] slot_task,
  output sched_mode_e       mode_q
);

  logic [REG_W-1:0]  word_q;
  logic [TASK_W-1:0] slot_arr [NUM_SLOTS];

  // Schedule word and mode; the reserved all-ones value selects rotation.
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      mode_q <= MODE_TABLE;
    end else if (wr_en) begin
      word_q <= wr_data;
      mode_q <= (wr_data == {REG_W{1'b1}}) ? MODE_TRIO : MODE_TABLE;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_arr[g] = word_q[g*TASK_W +: TASK_W];
  end

  assign slot_task = slot_arr[slot_idx];

  p_mode_table_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data != {REG_W{1'b1}}) |=> (mode_q == MODE_TABLE));

  p_mode_trio_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == {REG_W{1'b1}}) |=> (mode_q == MODE_TRIO));

endmodule

// File: rtl/tsched_seq.sv
module tsched_seq
  import tsched_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ROT_LEN   = 3,
  localparam int PTR_W    = $clog2(NUM_SLOTS),
  localparam int ROT_W    = $clog2(ROT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  input  sched_mode_e      mode,
  output logic [PTR_W-1:0] slot_idx,
  output logic [ROT_W-1:0] rot_idx
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_SLOTS - 1);
  localparam logic [ROT_W-1:0] LAST_ROT  = ROT_W'(ROT_LEN - 1);

  // Slot pointer: moves only in table mode.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      slot_idx <= '0;
    end else if (advance && mode == MODE_TABLE) begin
      slot_idx <= (slot_idx == LAST_SLOT) ? '0 : slot_idx + 1'b1;
    end
  end

  // Rotation counter: moves only in rotation mode.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      rot_idx <= '0;
    end else if (advance && mode == MODE_TRIO) begin
      rot_idx <= (rot_idx == LAST_ROT) ? '0 : rot_idx + 1'b1;
    end
  end

  p_restart_zero_r6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (slot_idx == '0 && rot_idx == '0));

  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !restart && mode == MODE_TABLE && slot_idx == LAST_SLOT) |=> (slot_idx == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!advance && !restart) |=> ($stable(slot_idx) && $stable(rot_idx)));

endmodule

// File: rtl/tsched_top.sv
module tsched_top
  import tsched_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_TASKS = 4,
  parameter int ROT_LEN   = 3,
  localparam int TASK_W   = $clog2(NUM_TASKS),
  localparam int REG_W    = NUM_SLOTS * TASK_W,
  localparam int PTR_W    = $clog2(NUM_SLOTS),
  localparam int ROT_W    = $clog2(ROT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sched_we,
  input  logic [REG_W-1:0]  sched_wdata,
  input  logic              stall,
  output logic [TASK_W-1:0] issue_task,
  output logic              issue_valid
);

  logic [PTR_W-1:0]  slot_idx;
  logic [ROT_W-1:0]  rot_idx;
  logic [TASK_W-1:0] slot_task;
  logic [TASK_W-1:0] next_task;
  sched_mode_e       mode_q;
  logic              advance;

  assign advance = !sched_we && !stall;

  tsched_table #(
    .NUM_SLOTS (NUM_SLOTS),
    .TASK_W    (TASK_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (sched_we),
    .wr_data   (sched_wdata),
    .slot_idx  (slot_idx),
    .slot_task (slot_task),
    .mode_q    (mode_q)
  );

  tsched_seq #(
    .NUM_SLOTS (NUM_SLOTS),
    .ROT_LEN   (ROT_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .restart  (sched_we),
    .advance  (advance),
    .mode     (mode_q),
    .slot_idx (slot_idx),
    .rot_idx  (rot_idx)
  );

  assign next_task = (mode_q == MODE_TRIO) ? TASK_W'(rot_idx) : slot_task;

  // Registered issue: write and stall cycles issue nothing, task holds.
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_task  <= '0;
      issue_valid <= 1'b0;
    end else if (!advance) begin
      issue_valid <= 1'b0;
    end else begin
      issue_task  <= next_task;
      issue_valid <= 1'b1;
    end
  end

  logic [TASK_W-1:0] trio_succ;
  assign trio_succ = (issue_task == TASK_W'(ROT_LEN - 1)) ? '0 : issue_task + 1'b1;

  p_write_gap_r6: assert property (@(posedge clk) disable iff (rst)
    sched_we |=> !issue_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (stall && !sched_we) |=> (!issue_valid && $stable(issue_task)));

  p_trio_range_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TRIO && issue_valid) |-> (issue_task < TASK_W'(ROT_LEN)));

  p_trio_order_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TRIO && issue_valid && advance) |=> (issue_valid && issue_task == $past(trio_succ)));

endmodule

// File: tb/tsched_top_test.sv
module tsched_top_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        sched_we;
  logic [31:0] sched_wdata;
  logic        stall;
  logic [1:0]  issue_task;
  logic        issue_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  tsched_top uut (
    .clk         (clk),
    .rst         (rst),
    .sched_we    (sched_we),
    .sched_wdata (sched_wdata),
    .stall       (stall),
    .issue_task  (issue_task),
    .issue_valid (issue_valid)
  );

  localparam int NPAT = 7;
  localparam logic [31:0] PAT [NPAT] = '{
    32'hE4E4_E4E4, 32'h5555_5555, 32'hAAAA_5555, 32'hFFFF_FFFF,
    32'h0000_0000, 32'hFFFF_FFFE, 32'h7FFF_FFFF
  };

  function automatic logic [1:0] exp_task(logic [31:0] w, int i);
    if (w == 32'hFFFF_FFFF) return 2'(i % 3);
    return w[2*(i % 16) +: 2];
  endfunction

  task automatic check(string tag, logic [1:0] t, logic v, logic [1:0] et, logic ev);
    n_checks++;
    if (t !== et || v !== ev) begin
      n_fail++;
      $display("FAIL %s: task=%0d valid=%0b expected task=%0d valid=%0b", tag, t, v, et, ev);
    end
  endtask

  // One cycle, then compare the registered outputs.
  task automatic step(string tag, logic [1:0] et, logic ev);
    @(negedge clk);
    check(tag, issue_task, issue_valid, et, ev);
  endtask

  // Write at the current negedge; the write edge must issue nothing (R6).
  task automatic load(logic [31:0] w);
    sched_we    = 1'b1;
    sched_wdata = w;
    @(negedge clk);
    sched_we    = 1'b0;
    n_checks++;
    if (issue_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R6: valid=%0b expected valid=0 after write", issue_valid);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; sched_we = 1'b0; sched_wdata = '0; stall = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", issue_task, issue_valid, 2'd0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) step("R1", 2'd0, 1'b1);

    // Vector table walk: each word loaded, then 40 issue cycles checked.
    for (int p = 0; p < NPAT; p++) begin
      load(PAT[p]);
      for (int i = 0; i < 40; i++) begin
        string tag;
        if (PAT[p] == 32'hFFFF_FFFF) tag = "R4";
        else if (p > 0 && PAT[p-1] == 32'hFFFF_FFFF) tag = "R9";
        else if (PAT[p] == 32'hFFFF_FFFE || PAT[p] == 32'h7FFF_FFFF) tag = "R5";
        else if (i >= 16) tag = "R3";
        else tag = "R2";
        step(tag, exp_task(PAT[p], i), 1'b1);
      end
    end

    // R7: stall mid-table; slot 5 (task 1) issued last, then hold.
    load(32'hE4E4_E4E4);
    for (int i = 0; i < 6; i++) step("R2", exp_task(32'hE4E4_E4E4, i), 1'b1);
    stall = 1'b1;
    for (int i = 0; i < 3; i++) step("R7", 2'd1, 1'b0);
    stall = 1'b0;
    step("R7", 2'd2, 1'b1);
    step("R7", 2'd3, 1'b1);

    // R7: stall in rotation mode after issuing 0,1.
    load(32'hFFFF_FFFF);
    step("R4", 2'd0, 1'b1);
    step("R4", 2'd1, 1'b1);
    stall = 1'b1;
    for (int i = 0; i < 4; i++) step("R7", 2'd1, 1'b0);
    stall = 1'b0;
    step("R7", 2'd2, 1'b1);
    step("R7", 2'd0, 1'b1);
    step("R7", 2'd1, 1'b1);

    // R8: write taken while stalled restarts at slot 0.
    stall = 1'b1;
    load(32'h0000_00E7);
    step("R8", 2'd1, 1'b0);
    step("R8", 2'd1, 1'b0);
    stall = 1'b0;
    step("R8", 2'd3, 1'b1);
    step("R8", 2'd1, 1'b1);
    step("R8", 2'd2, 1'b1);
    step("R8", 2'd3, 1'b1);
    step("R8", 2'd0, 1'b1);

    // R8 in rotation mode: write all ones during a stall, restart at task 0.
    stall = 1'b1;
    load(32'hFFFF_FFFF);
    step("R8", 2'd0, 1'b0);
    stall = 1'b0;
    step("R8", 2'd0, 1'b1);
    step("R8", 2'd1, 1'b1);

    // R1: reset mid-run clears outputs and the schedule word.
    rst = 1'b1;
    @(negedge clk);
    check("R1", issue_task, issue_valid, 2'd0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) step("R1", 2'd0, 1'b1);

    finish_run();
  end

endmodule